// File: doc/BRIEF.md
# Strobe-aligned serial byte receiver

This block turns a serial bitstream, clocked by an external data clock, into parallel bytes inside a faster system clock domain. A separate sync strobe sets the byte boundaries. A byte begins on the first data-clock sampling edge that sees the strobe high. If the strobe is still high when the last bit of a byte is sampled, the next bits run on into a further byte without a new sync. Every completed byte is presented on `byte_out` together with a one-cycle `byte_vld` pulse.

Three static configuration inputs set how the block receives. The first picks the sampling edge of the data clock. The second picks the bit order within a byte. The third selects passive mode. In passive mode a bit counts only while the strobe is high, and a fresh rising edge of the strobe partway through a byte discards the partial byte and raises `frame_err` for one cycle. The data clock, data and strobe pass through synchronizers, and their edges are found by comparing registered samples.

Top module: `sync_byte_rx`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, `byte_vld` and `frame_err` are 0 and `byte_out` is 0.
- R2: With `cfg_fall`=0 bits are sampled on rising edges of `ser_clk`. With `cfg_fall`=1 they are sampled on falling edges. Edges of the other direction take no bit.
- R3: While idle, a sampling edge with `ser_sync` low takes no bit. The first sampling edge with `ser_sync` high takes the first bit of a new byte.
- R4: With `cfg_lsb_first`=1 the first bit received lands in `byte_out[0]` and the eighth in `byte_out[7]`. With `cfg_lsb_first`=0 the first bit lands in `byte_out[7]`.
- R5: In normal mode (`cfg_passive`=0), once a byte has begun, its remaining seven bits are taken whatever the level of `ser_sync`.
- R6: In normal mode, if `ser_sync` is high at the eighth bit, the next eight sampling edges form a further byte with no new sync. If `ser_sync` is low at the eighth bit, the receiver goes idle.
- R7: In passive mode a bit is taken only on sampling edges where `ser_sync` is high. Edges with `ser_sync` low add nothing.
- R8: In passive mode a rising edge of `ser_sync` restarts alignment. If it arrives with one to seven bits of a byte already held, those bits are discarded and `frame_err` pulses for one cycle, never together with `byte_vld`.
- R9: `byte_vld` is high for exactly one system clock cycle per completed byte. `byte_out` changes only in a cycle where `byte_vld` is high.
- R10: `byte_vld` is seen high after the third rising edge of `clk` that follows the `ser_clk` sampling edge carrying the eighth bit.
- R11: `frame_err` stays 0 in normal mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, synchronous to `clk` |
| ser_clk | input | 1 | Serial data clock, asynchronous to `clk` |
| ser_dat | input | 1 | Serial data |
| ser_sync | input | 1 | Byte sync strobe |
| cfg_fall | input | 1 | 1: sample on falling `ser_clk` edge, 0: rising |
| cfg_lsb_first | input | 1 | 1: first bit is bit 0, 0: first bit is bit 7 |
| cfg_passive | input | 1 | 1: passive mode, bits only while strobe high |
| byte_out | output | 8 | Last completed byte |
| byte_vld | output | 1 | One-cycle pulse per completed byte |
| frame_err | output | 1 | One-cycle pulse when a partial byte is discarded |

## Verification
A serial edge reaches the receiver's state two system clock edges after it happens, and the byte register is loaded on the edge after that. So `byte_vld` is due after the third `clk` rise following the edge that carries the eighth bit, and `frame_err` has the same delay after a strobe rise. The bench holds every serial level for four system cycles, collects pulses at falling `clk` edges into a log, and compares that log only once the transfer has settled. One directed test counts falling `clk` edges from the final serial edge to the `byte_vld` pulse and expects three.

// File: rtl/sbr_pkg.sv
package sbr_pkg;
  // Position within the byte for the n-th received bit.
  function automatic int unsigned sbr_bit_pos(int unsigned nth, logic lsb_first,
                                              int unsigned width);
    return lsb_first ? nth : (width - 1 - nth);
  endfunction

  // Detect a sampling edge from two registered clock samples.
  function automatic logic sbr_is_sample(logic now_v, logic prev_v, logic fall_sel);
    return fall_sel ? (prev_v & ~now_v) : (now_v & ~prev_v);
  endfunction
endpackage

// File: rtl/sbr_sync.sv
module sbr_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d_in[g]};
    end
    assign d_out[g] = chain[STAGES-1];
  end
endmodule

// File: rtl/sbr_edge.sv
module sbr_edge
  import sbr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_fall,
  input  logic sclk_s,
  input  logic strobe_s,
  output logic samp_evt,
  output logic strobe_rise
);
  logic sclk_q, strobe_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q   <= 1'b0;
      strobe_q <= 1'b0;
    end else begin
      sclk_q   <= sclk_s;
      strobe_q <= strobe_s;
    end
  end

  assign samp_evt    = sbr_is_sample(sclk_s, sclk_q, cfg_fall);
  assign strobe_rise = strobe_s & ~strobe_q;
endmodule

// File: rtl/sbr_assemble.sv
module sbr_assemble
  import sbr_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_lsb_first,
  input  logic              cfg_passive,
  input  logic              samp_evt,
  input  logic              strobe_rise,
  input  logic              strobe_lvl,
  input  logic              dat_s,
  output logic [DATA_W-1:0] byte_out,
  output logic              byte_vld,
  output logic              frame_err,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic              take_bit
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic              active;
  logic [DATA_W-1:0] shreg, merged;
  logic              restart;
  logic [CNT_W-1:0]  eff_cnt, pos;

  assign restart  = cfg_passive & strobe_rise;
  assign eff_cnt  = restart ? '0 : bit_cnt;
  assign take_bit = samp_evt & (cfg_passive ? strobe_lvl : (active | strobe_lvl));
  assign pos      = CNT_W'(sbr_bit_pos(32'(eff_cnt), cfg_lsb_first, DATA_W));

  always_comb begin
    merged      = shreg;
    merged[pos] = dat_s;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active    <= 1'b0;
      shreg     <= '0;
      bit_cnt   <= '0;
      byte_out  <= '0;
      byte_vld  <= 1'b0;
      frame_err <= 1'b0;
    end else begin
      byte_vld  <= 1'b0;
      frame_err <= restart && (bit_cnt != '0);
      if (take_bit) begin
        shreg <= merged;
        if (eff_cnt == LAST) begin
          byte_out <= merged;
          byte_vld <= 1'b1;
          bit_cnt  <= '0;
          active   <= ~cfg_passive & strobe_lvl;
        end else begin
          bit_cnt <= eff_cnt + 1'b1;
          active  <= ~cfg_passive;
        end
      end else if (restart) begin
        bit_cnt <= '0;
      end
    end
  end
endmodule

// File: rtl/sync_byte_rx.sv
module sync_byte_rx #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_dat,
  input  logic              ser_sync,
  input  logic              cfg_fall,
  input  logic              cfg_lsb_first,
  input  logic              cfg_passive,
  output logic [DATA_W-1:0] byte_out,
  output logic              byte_vld,
  output logic              frame_err
);
  logic [2:0]       sync_bus;
  logic             samp_evt, strobe_rise, take_bit;
  logic [CNT_W-1:0] bit_cnt;

  sbr_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  ({ser_sync, ser_dat, ser_clk}),
    .d_out (sync_bus)
  );

  sbr_edge u_edge (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_fall    (cfg_fall),
    .sclk_s      (sync_bus[0]),
    .strobe_s    (sync_bus[2]),
    .samp_evt    (samp_evt),
    .strobe_rise (strobe_rise)
  );

  sbr_assemble #(.DATA_W(DATA_W)) u_asm (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_lsb_first (cfg_lsb_first),
    .cfg_passive   (cfg_passive),
    .samp_evt      (samp_evt),
    .strobe_rise   (strobe_rise),
    .strobe_lvl    (sync_bus[2]),
    .dat_s         (sync_bus[1]),
    .byte_out      (byte_out),
    .byte_vld      (byte_vld),
    .frame_err     (frame_err),
    .bit_cnt       (bit_cnt),
    .take_bit      (take_bit)
  );
endmodule

// File: rtl/sbr_checks.sv
module sbr_checks #(
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_passive,
  input logic [DATA_W-1:0] byte_out,
  input logic              byte_vld,
  input logic              frame_err,
  input logic              take_bit,
  input logic [CNT_W-1:0]  bit_cnt
);
  // R9: valid lasts one cycle
  assert_vld_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |=> !byte_vld);

  // R9: data register moves only with valid
  assert_out_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_vld |-> $stable(byte_out));

  // R10: a byte completes only on a cycle after a bit was taken
  assert_vld_after_bit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |-> $past(take_bit));

  // R11: framing error only in passive mode
  assert_no_err_normal_R11: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> cfg_passive);

  // R8: discarded byte never coincides with a delivered byte
  assert_err_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> !byte_vld);

  // R6: bit counter restarts after a completed byte
  assert_cnt_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |-> (bit_cnt == '0));
endmodule

bind sync_byte_rx sbr_checks #(.DATA_W(DATA_W)) u_checks (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_passive (cfg_passive),
  .byte_out    (byte_out),
  .byte_vld    (byte_vld),
  .frame_err   (frame_err),
  .take_bit    (take_bit),
  .bit_cnt     (bit_cnt)
);

// File: tb/sync_byte_rx_test.sv
module sync_byte_rx_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ser_clk = 1'b0, ser_dat = 1'b0, ser_sync = 1'b0;
  logic       cfg_fall = 1'b0, cfg_lsb_first = 1'b0, cfg_passive = 1'b0;
  logic [7:0] byte_out;
  logic       byte_vld, frame_err;

  int n_tests = 0, n_fail = 0;
  int ncap = 0, nerr = 0;
  logic [7:0] cap [0:127];

  always #4 clk = ~clk;  // 125 MHz

  sync_byte_rx uut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .ser_sync(ser_sync), .cfg_fall(cfg_fall), .cfg_lsb_first(cfg_lsb_first),
    .cfg_passive(cfg_passive), .byte_out(byte_out), .byte_vld(byte_vld),
    .frame_err(frame_err)
  );

  // Log of delivered bytes and framing errors, sampled away from the edge.
  always @(negedge clk) begin
    if (rst_n) begin
      if (byte_vld) begin
        cap[ncap[6:0]] = byte_out;
        ncap++;
      end
      if (frame_err) nerr++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One serial bit: set levels, then the sampling edge, then return to idle.
  task automatic ser_bit(input logic d, input logic s);
    ser_dat = d; ser_sync = s;
    repeat (4) @(negedge clk);
    ser_clk = ~ser_clk;
    repeat (4) @(negedge clk);
    ser_clk = ~ser_clk;
  endtask

  task automatic settle();
    ser_sync = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic set_cfg(input logic f, input logic l, input logic p);
    ser_sync = 1'b0;
    cfg_fall = f; cfg_lsb_first = l; cfg_passive = p;
    repeat (4) @(negedge clk);
    ser_clk = f;  // idle level: sample edge goes away from it
    repeat (8) @(negedge clk);
  endtask

  // Send one byte; sync pattern chosen per bit by mode.
  task automatic send_byte(input logic [7:0] b, input logic hold_all, input logic last_s);
    for (int i = 0; i < 8; i++) begin
      logic s;
      s = (i == 0) ? 1'b1 : ((i == 7) ? last_s : hold_all);
      ser_bit(cfg_lsb_first ? b[i] : b[7-i], s);
    end
  endtask

  // Vector table: {fall, lsb_first, two_bytes, byte0, byte1}
  localparam int NV = 6;
  localparam logic [18:0] VEC [NV] = '{
    {1'b0, 1'b0, 1'b0, 8'hA5, 8'h00},
    {1'b0, 1'b1, 1'b0, 8'h81, 8'h00},
    {1'b1, 1'b0, 1'b0, 8'h3C, 8'h00},
    {1'b1, 1'b1, 1'b0, 8'hC4, 8'h00},
    {1'b0, 1'b1, 1'b1, 8'h12, 8'hF0},
    {1'b1, 1'b0, 1'b1, 8'h6E, 8'h09}
  };

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(byte_vld == 1'b0 && frame_err == 1'b0 && byte_out == 8'h00, "R1 in reset",
        {byte_vld, frame_err, byte_out}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(byte_vld == 1'b0 && frame_err == 1'b0 && byte_out == 8'h00, "R1 after reset",
        {byte_vld, frame_err, byte_out}, 0);

    // Table walk: R2 edge select, R4 order, R5 strobe ignored mid-byte, R6 run-on
    for (int v = 0; v < NV; v++) begin
      logic [18:0] e;
      e = VEC[v];
      set_cfg(e[18], e[17], 1'b0);
      base = ncap;
      if (e[16]) begin
        send_byte(e[15:8], 1'b1, 1'b1);
        send_byte(e[7:0], 1'b0, 1'b0);
      end else begin
        send_byte(e[15:8], 1'b0, 1'b0);
      end
      settle();
      chk(ncap - base == (e[16] ? 2 : 1), "R2 R6 byte count", ncap - base, e[16] ? 2 : 1);
      chk(cap[base[6:0]] == e[15:8], "R4 R5 first byte", cap[base[6:0]], e[15:8]);
      if (e[16])
        chk(cap[base[6:0] + 7'd1] == e[7:0], "R6 run-on byte", cap[base[6:0] + 7'd1], e[7:0]);
    end

    // R3 and R6: idle edges with strobe low take nothing
    set_cfg(1'b0, 1'b0, 1'b0);
    base = ncap;
    for (int i = 0; i < 12; i++) ser_bit(1'b1, 1'b0);
    settle();
    chk(ncap == base, "R3 idle edges ignored", ncap - base, 0);
    send_byte(8'h5A, 1'b0, 1'b0);
    settle();
    chk(ncap - base == 1 && cap[base[6:0]] == 8'h5A, "R3 start after idle",
        cap[base[6:0]], 8'h5A);

    // R10: latency from last sampling edge to valid
    begin
      int lat;
      lat = 0;
      for (int i = 0; i < 7; i++) ser_bit(1'b0, i == 0);
      ser_dat = 1'b1; ser_sync = 1'b0;
      repeat (4) @(negedge clk);
      ser_clk = ~ser_clk;
      for (int c = 1; c <= 8; c++) begin
        @(negedge clk);
        if (byte_vld && lat == 0) lat = c;
      end
      ser_clk = ~ser_clk;
      chk(lat == 3, "R10 latency", lat, 3);
      settle();
    end

    // R11: no framing error across normal-mode traffic
    chk(nerr == 0, "R11 no frame_err in normal mode", nerr, 0);

    // R7: passive mode, a sync on only the first bit gives no byte
    set_cfg(1'b0, 1'b0, 1'b1);
    base = ncap;
    send_byte(8'hFF, 1'b0, 1'b0);
    for (int i = 0; i < 6; i++) ser_bit(1'b1, 1'b0);
    settle();
    chk(ncap == base, "R7 passive low-strobe bits skipped", ncap - base, 0);

    // R8: new strobe rise discards the held bit and flags it
    send_byte(8'h96, 1'b1, 1'b1);
    settle();
    chk(nerr == 1, "R8 frame_err pulse", nerr, 1);
    chk(ncap - base == 1 && cap[base[6:0]] == 8'h96, "R8 byte after restart",
        cap[base[6:0]], 8'h96);

    // R8: partial byte then fresh strobe, falling edge, LSB first
    set_cfg(1'b1, 1'b1, 1'b1);
    base = ncap;
    for (int i = 0; i < 3; i++) ser_bit(1'b1, 1'b1);
    ser_sync = 1'b0;
    repeat (8) @(negedge clk);
    send_byte(8'h2B, 1'b1, 1'b0);
    settle();
    chk(nerr == 2, "R8 second frame_err", nerr, 2);
    chk(ncap - base == 0, "R7 last bit with strobe low not taken", ncap - base, 0);
    ser_bit(1'b0, 1'b1);  // restarts, one bit held
    settle();

    // R7: full-high passive transfer of two bytes
    set_cfg(1'b0, 1'b0, 1'b1);
    base = ncap;
    send_byte(8'hE7, 1'b1, 1'b1);
    send_byte(8'h18, 1'b1, 1'b1);
    settle();
    chk(ncap - base == 2, "R7 passive two bytes", ncap - base, 2);
    chk(cap[base[6:0]] == 8'hE7 && cap[base[6:0] + 7'd1] == 8'h18, "R7 passive data",
        {cap[base[6:0]], cap[base[6:0] + 7'd1]}, 16'hE718);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule